// File: doc/BRIEF.md
# Set-Associative Cache Tag and Replacement Unit

This unit holds the tag, valid, dirty and usage state of a small set-associative cache and answers one lookup per cycle. A byte address is cut into three parts: a tag in the upper bits, a set index in the middle bits, and a byte offset in the low bits that plays no part in the lookup. Every way of the chosen set compares its stored tag with the request in parallel. The unit reports whether any way matched and which way it was.

On a miss the unit picks a way to replace and loads the new tag into it in the same clock edge. Each line has a small usage counter that is set to its highest value whenever the line is touched. A periodic tick input lowers every counter by one, so lines that have not been used for a while drift toward zero and become the first candidates for replacement. This approximates least-recently-used order with a few bits per line. A write-back mode input decides whether writes mark lines dirty. When a dirty victim is replaced, the unit tells the memory side that two transfers are needed: the old line goes out first, then the new line comes in.

Top module: `sacache_top`

## Requirements
- R1: The lookup uses tag = reqAddr[31:4] and set = reqAddr[3:2]. The offset reqAddr[1:0] is ignored, so two requests that differ only in the offset find the same line.
- R2: With reqValid high, hit is 1 exactly when a valid way of the addressed set holds the request tag, and hitWay gives that way. With reqValid low, hit, writeBack and memAccesses are all 0.
- R3: After reset no line is valid. The first request to any set misses, shows victimWay 0, and reports memAccesses 1.
- R4: A miss loads the request tag into the victim way and marks it valid. An immediately repeated request to the same address hits.
- R5: A write with wbMode=1 sets the dirty bit of the line it hits or fills. Reads never set the dirty bit, and neither do writes with wbMode=0.
- R6: An access sets the line's 2-bit usage counter to 3. A tick lowers every nonzero counter by one. When a tick and an access land in the same cycle, the accessed line ends at 3 and every other line decays.
- R7: Victim choice runs in three steps. The lowest-numbered invalid way wins first. If every way is valid, the lowest-numbered way whose counter is zero is taken. If no counter is zero, the lowest-numbered way holding the smallest count is taken.
- R8: memAccesses is 0 on a hit and 1 on a miss with a clean or invalid victim. On a miss whose victim is valid and dirty it is 2, and writeBack is 1 in that case only.
- R9: Sets are independent. A tag stored in one set never produces a hit for a request to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A lookup is presented this cycle |
| reqAddr | input | 32 | Byte address of the lookup |
| reqWrite | input | 1 | The lookup is a write |
| wbMode | input | 1 | 1 = write-back (writes mark lines dirty), 0 = write-through |
| tick | input | 1 | Decay strobe for all usage counters |
| hit | output | 1 | The request matched a valid way |
| hitWay | output | 2 | The way that matched |
| victimWay | output | 2 | The way a miss would replace in the addressed set |
| writeBack | output | 1 | This miss evicts a dirty line |
| memAccesses | output | 2 | Memory transfers needed by this request (0, 1 or 2) |

## Verification
Directed sequences first fill one set way by way, which shows that invalid ways are chosen in order. Another set is written in write-back mode and then decayed with ticks, so its eviction must report two transfers. The same sequence in write-through mode shows that writes there leave no dirty line. A fourth set takes a tick in the same cycle as an access while every counter is nonzero. That case separates "the accessed line stays at the top count" from "it decays with the rest", because the smallest-count choice lands on a different way. Seeded random traffic then uses only a few tags over all sets, with mixed reads, writes, modes and ticks. This causes frequent conflicts, offset-only changes and cross-set aliasing, and every output is compared with a bench model each cycle.

// File: rtl/sacache_pkg.sv
package sacache_pkg;
  // Strobes the control side hands to the state-holding datapath each cycle.
  typedef struct packed {
    logic touch;      // refresh usage of the selected way (hit)
    logic fill;       // load a new tag into the selected way (miss)
    logic markDirty;  // write in write-back mode
    logic decay;      // periodic counter decrement
  } cacheStrobes_t;
endpackage

// File: rtl/sacache_datapath.sv
module sacache_datapath
  import sacache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SET_BITS  = 2,
  parameter int OFFS_BITS = 2,
  parameter int WAYS      = 4,
  parameter int CNT_W     = 2,
  localparam int TAG_W = ADDR_W - SET_BITS - OFFS_BITS,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  cacheStrobes_t     stb,
  input  logic [WAY_W-1:0]  selWay,
  output logic              hitAny,
  output logic [WAY_W-1:0]  hitWay,
  output logic [WAY_W-1:0]  victimWay,
  output logic              victimValid,
  output logic              victimDirty
);
  localparam int SETS = 1 << SET_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'((1 << CNT_W) - 1);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic             validMem [SETS][WAYS];
  logic             dirtyMem [SETS][WAYS];
  logic [CNT_W-1:0] cntMem   [SETS][WAYS];

  logic [SET_BITS-1:0] setIdx;
  logic [TAG_W-1:0]    tagIn;
  assign setIdx = addr[OFFS_BITS +: SET_BITS];
  assign tagIn  = addr[ADDR_W-1 -: TAG_W];

  // Parallel tag compare across the set.
  logic [WAYS-1:0] matchVec;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign matchVec[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == tagIn);
  end

  always_comb begin
    hitAny = |matchVec;
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (matchVec[w]) hitWay = WAY_W'(w);
  end

  // Victim: lowest invalid way, else lowest way with the minimum count
  // (a zero count, when present, is the minimum, so it wins there too).
  logic             foundInv;
  logic [WAY_W-1:0] invWay, minWay;
  logic [CNT_W-1:0] minCnt;
  always_comb begin
    foundInv = 1'b0;
    invWay   = '0;
    minWay   = '0;
    minCnt   = cntMem[setIdx][0];
    for (int w = 0; w < WAYS; w++) begin
      if (!validMem[setIdx][w] && !foundInv) begin
        foundInv = 1'b1;
        invWay   = WAY_W'(w);
      end
      if (cntMem[setIdx][w] < minCnt) begin
        minCnt = cntMem[setIdx][w];
        minWay = WAY_W'(w);
      end
    end
    victimWay = foundInv ? invWay : minWay;
  end

  assign victimValid = validMem[setIdx][victimWay];
  assign victimDirty = dirtyMem[setIdx][victimWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w]   <= '0;
          validMem[s][w] <= 1'b0;
          dirtyMem[s][w] <= 1'b0;
          cntMem[s][w]   <= '0;
        end
    end else begin
      if (stb.decay)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (cntMem[s][w] != '0) cntMem[s][w] <= cntMem[s][w] - 1'b1;
      // Later assignment wins: an accessed line ends at the top count.
      if (stb.touch || stb.fill) cntMem[setIdx][selWay] <= CNT_MAX;
      if (stb.fill) begin
        tagMem[setIdx][selWay]   <= tagIn;
        validMem[setIdx][selWay] <= 1'b1;
        dirtyMem[setIdx][selWay] <= stb.markDirty;
      end else if (stb.touch && stb.markDirty) begin
        dirtyMem[setIdx][selWay] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sacache_control.sv
module sacache_control
  import sacache_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             wbMode,
  input  logic             tick,
  input  logic             hitAny,
  input  logic [WAY_W-1:0] hitWay,
  input  logic [WAY_W-1:0] victimWay,
  input  logic             victimValid,
  input  logic             victimDirty,
  output cacheStrobes_t    stb,
  output logic [WAY_W-1:0] selWay,
  output logic             hit,
  output logic             writeBack,
  output logic [1:0]       memAccesses
);
  logic missNow;
  assign missNow = reqValid && !hitAny;

  always_comb begin
    stb.touch     = reqValid && hitAny;
    stb.fill      = missNow;
    stb.markDirty = reqValid && reqWrite && wbMode;
    stb.decay     = tick;
  end

  assign selWay      = hitAny ? hitWay : victimWay;
  assign hit         = reqValid && hitAny;
  assign writeBack   = missNow && victimValid && victimDirty;
  assign memAccesses = !missNow ? 2'd0 : (writeBack ? 2'd2 : 2'd1);
endmodule

// File: rtl/sacache_top.sv
module sacache_top
  import sacache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SET_BITS  = 2,
  parameter int OFFS_BITS = 2,
  parameter int WAYS      = 4,
  parameter int CNT_W     = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              wbMode,
  input  logic              tick,
  output logic              hit,
  output logic [WAY_W-1:0]  hitWay,
  output logic [WAY_W-1:0]  victimWay,
  output logic              writeBack,
  output logic [1:0]        memAccesses
);
  cacheStrobes_t    stb;
  logic [WAY_W-1:0] selWay;
  logic             hitAny, victimValid, victimDirty;

  sacache_datapath #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .OFFS_BITS(OFFS_BITS),
    .WAYS(WAYS), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .addr(reqAddr), .stb(stb), .selWay(selWay),
    .hitAny(hitAny), .hitWay(hitWay), .victimWay(victimWay),
    .victimValid(victimValid), .victimDirty(victimDirty)
  );

  sacache_control #(.WAYS(WAYS)) ctl_i (
    .reqValid(reqValid), .reqWrite(reqWrite), .wbMode(wbMode), .tick(tick),
    .hitAny(hitAny), .hitWay(hitWay), .victimWay(victimWay),
    .victimValid(victimValid), .victimDirty(victimDirty),
    .stb(stb), .selWay(selWay), .hit(hit), .writeBack(writeBack),
    .memAccesses(memAccesses)
  );
endmodule

// File: rtl/sacache_checker.sv
module sacache_checker #(
  parameter int ADDR_W    = 32,
  parameter int OFFS_BITS = 2,
  parameter int WAY_W     = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              hit,
  input logic              writeBack,
  input logic [1:0]        memAccesses
);
  p_wb_on_dirty_miss_r8: assert property (@(posedge clk) disable iff (!rstN)
    writeBack |-> (reqValid && !hit && memAccesses == 2'd2));

  p_hit_costs_nothing_r8: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (memAccesses == 2'd0));

  p_miss_costs_memory_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hit) |-> (memAccesses != 2'd0));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!hit && !writeBack && memAccesses == 2'd0));

  p_repeat_hits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(reqValid) && reqAddr == $past(reqAddr)) |-> hit);

  p_offset_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(reqValid) &&
     reqAddr[ADDR_W-1:OFFS_BITS] == $past(reqAddr[ADDR_W-1:OFFS_BITS])) |-> hit);
endmodule

bind sacache_top sacache_checker #(
  .ADDR_W(ADDR_W), .OFFS_BITS(OFFS_BITS), .WAY_W(WAY_W)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .hit(hit), .writeBack(writeBack), .memAccesses(memAccesses)
);

// File: tb/sacache_tb.sv
module sacache_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, wbMode, tick;
  logic [31:0] reqAddr;
  logic        hit, writeBack;
  logic [1:0]  hitWay, victimWay, memAccesses;

  int total = 0;
  int bad   = 0;

  // Bench model of the tag state, 4 sets x 4 ways, 2-bit counters.
  logic [27:0] mTag   [4][4];
  logic        mValid [4][4];
  logic        mDirty [4][4];
  int          mCnt   [4][4];

  int gotHit, gotWay, gotVictim, gotWb, gotMem;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sacache_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .wbMode(wbMode), .tick(tick), .hit(hit),
    .hitWay(hitWay), .victimWay(victimWay), .writeBack(writeBack),
    .memAccesses(memAccesses)
  );

  function automatic logic [31:0] mk(int tag, int set, int off);
    return (32'(tag) << 4) | (32'(set) << 2) | 32'(off);
  endfunction

  task automatic chk(string lab, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", lab, act, exp);
    end
  endtask

  task automatic doCycle(logic v, logic [31:0] a, logic isWr, logic wb,
                         logic tk, string lab);
    int s, eWay, vic, minC, eMem;
    logic [27:0] t;
    logic eHit, foundInv, eWb;
    @(negedge clk);
    reqValid = v; reqAddr = a; reqWrite = isWr; wbMode = wb; tick = tk;
    #1;
    s = int'(a[3:2]);
    t = a[31:4];
    eHit = 1'b0; eWay = 0;
    for (int w = 3; w >= 0; w--)
      if (mValid[s][w] && mTag[s][w] == t) begin eHit = 1'b1; eWay = w; end
    foundInv = 1'b0; vic = 0; minC = mCnt[s][0];
    for (int w = 0; w < 4; w++)
      if (!mValid[s][w] && !foundInv) begin foundInv = 1'b1; vic = w; end
    if (!foundInv)
      for (int w = 0; w < 4; w++)
        if (mCnt[s][w] < minC) begin minC = mCnt[s][w]; vic = w; end
    eWb  = v && !eHit && mValid[s][vic] && mDirty[s][vic];
    eMem = (!v || eHit) ? 0 : (eWb ? 2 : 1);
    gotHit = int'(hit); gotWay = int'(hitWay); gotVictim = int'(victimWay);
    gotWb = int'(writeBack); gotMem = int'(memAccesses);
    chk({lab, " hit"}, gotHit, int'(v && eHit));
    if (v && eHit) chk({lab, " hitWay"}, gotWay, eWay);
    chk("R7 victimWay", gotVictim, vic);
    chk("R8 writeBack", gotWb, int'(eWb));
    chk("R8 memAccesses", gotMem, eMem);
    // Model update for the coming edge.
    if (tk)
      for (int ss = 0; ss < 4; ss++)
        for (int w = 0; w < 4; w++)
          if (mCnt[ss][w] > 0) mCnt[ss][w]--;
    if (v) begin
      if (eHit) begin
        mCnt[s][eWay] = 3;
        if (isWr && wb) mDirty[s][eWay] = 1'b1;
      end else begin
        mTag[s][vic] = t; mValid[s][vic] = 1'b1;
        mDirty[s][vic] = isWr && wb; mCnt[s][vic] = 3;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        mTag[s][w] = '0; mValid[s][w] = 1'b0; mDirty[s][w] = 1'b0; mCnt[s][w] = 0;
      end
    rstN = 1'b0; reqValid = 0; reqAddr = '0; reqWrite = 0; wbMode = 0; tick = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3: nothing valid after reset.
    doCycle(1, mk(1, 0, 0), 0, 1, 0, "R3");
    chk("R3 first miss", gotHit, 0);
    chk("R3 victim", gotVictim, 0);
    chk("R3 one access", gotMem, 1);
    // R7: invalid ways are taken lowest first.
    for (int k = 2; k <= 4; k++) begin
      doCycle(1, mk(k, 0, 0), 0, 1, 0, "R4");
      chk("R7 invalid order", gotVictim, k - 1);
    end
    // R1: the offset is ignored.
    doCycle(1, mk(3, 0, 3), 0, 1, 0, "R1");
    chk("R1 offset hit", gotHit, 1);
    chk("R1 offset way", gotWay, 2);
    // R9: the same tag in another set misses.
    doCycle(1, mk(3, 1, 0), 0, 1, 0, "R9");
    chk("R9 other set", gotHit, 0);

    // R5/R8: dirty eviction in set 2.
    doCycle(1, mk(1, 2, 0), 1, 1, 0, "R5");
    for (int k = 2; k <= 4; k++) doCycle(1, mk(k, 2, 0), 0, 1, 0, "R4");
    repeat (3) doCycle(0, '0, 0, 1, 1, "R6");
    doCycle(1, mk(5, 2, 0), 0, 1, 0, "R8");
    chk("R5 dirty victim way", gotVictim, 0);
    chk("R8 writeBack", gotWb, 1);
    chk("R8 two accesses", gotMem, 2);

    // R5: write-through never dirties (set 3).
    doCycle(1, mk(1, 3, 0), 1, 0, 0, "R5");
    doCycle(1, mk(1, 3, 1), 1, 0, 0, "R5");
    for (int k = 2; k <= 4; k++) doCycle(1, mk(k, 3, 0), 0, 0, 0, "R4");
    repeat (3) doCycle(0, '0, 0, 0, 1, "R6");
    doCycle(1, mk(6, 3, 0), 0, 0, 0, "R5");
    chk("R5 write-through clean", gotWb, 0);
    chk("R5 one access", gotMem, 1);

    // R6: access during a tick keeps the top count (set 1).
    for (int k = 4; k <= 6; k++) doCycle(1, mk(k, 1, 0), 0, 1, 0, "R4");
    doCycle(1, mk(3, 1, 0), 0, 1, 0, "R6");
    doCycle(1, mk(3, 1, 0), 0, 1, 1, "R6");
    doCycle(1, mk(9, 1, 0), 0, 1, 0, "R6");
    chk("R6 tick with access", gotVictim, 1);

    // Seeded random traffic over few tags.
    for (int n = 0; n < 3000; n++)
      doCycle($urandom_range(0, 7) != 0,
              mk($urandom_range(0, 5), $urandom_range(0, 3), $urandom_range(0, 3)),
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              $urandom_range(0, 3) == 0, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule